// File: doc/BRIEF.md
# Modem Host Register Interface

This block is the host-facing register port of a modem controller. A host processor reaches it over an 8-bit multiplexed address/data bus. A transfer has two steps. First the host pulses an address-latch strobe. While that strobe falls, the block takes a 3-bit register address and the chip-select level. Then the host issues a read strobe or a write strobe. The register file holds two control registers, a tone register and a read-only detect register. The detect register collects event pulses from the modem core.

The bus signals are sampled on the system clock. The bidirectional bus is split into a data input, a data output and an output enable. The open-drain interrupt is modelled as an active-low level plus a drive enable. The modulation mode and a clock-request bit in the control registers pick what a clock output pin carries: the crystal clock or a 16x baud clock. A small divider stub stands in for the baud clock.

Top module: `modem_host_regif`

## Requirements
- R1: The register address is `ad_in[2:0]` as sampled at the first clock edge where `ale` is low after being high. Later changes of `ad_in` do not redirect the transfer that follows.
- R2: Chip select (active low) is taken at that same edge and held. The live `cs_n` pin has no effect on the following read or write.
- R3: `ad_oe` is high only while `rd_n` is low and the held chip select is active. `ad_out` is zero whenever `ad_oe` is low.
- R4: A write happens at the first clock edge where `wr_n` is high after being low, using `ad_in` at that edge. Nothing is written when the held chip select is inactive.
- R5: Address map: 0 is control A, 1 is control B, 3 is tone, and all three read back what was written. Address 2 is the detect register, and writes to it are ignored. Addresses 4 to 7 read as zero and ignore writes.
- R6: A one-cycle pulse on `det_evt[i]` sets detect flag i, which reads back as bit i of address 2. While any flag is set, `irq_oe` is high and `irq_n` is low.
- R7: A read of address 2 starts when `rd_n` falls with the held chip select active. It returns the flags as they stood at that start, with data valid from the next clock edge. It clears every flag and releases the interrupt.
- R8: An event pulse in the cycle a detect read starts, or later, is not lost. It is returned by the next detect read.
- R9: An active-high `rst` clears both control registers, the tone register and the flags. It returns the clock output to the crystal choice (`clko_sel` = 0).
- R10: `clko_sel` is 1 only when control B bit 4 is 1 and control A bits [1:0] select a DPSK mode (01 or 10). Modes 00 and 11 keep the crystal clock.
- R11: With `clko_sel` = 1, `clko_baud` toggles every `DIV_LO/2` clocks in mode 01 and every `DIV_HI/2` clocks in mode 10. With `clko_sel` = 0 it is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all bus strobes are sampled on it |
| rst | input | 1 | Active-high reset, asynchronous assert |
| ale | input | 1 | Address-latch strobe; address and chip select are taken on its fall |
| cs_n | input | 1 | Chip select, active low, latched with the address |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; write lands on its rise |
| ad_in | input | DW | Bus value as seen by the block |
| ad_out | output | DW | Read data driven toward the bus |
| ad_oe | output | 1 | Bus drive enable |
| det_evt | input | NDET | One-cycle detect event pulses |
| irq_n | output | 1 | Interrupt level, active low |
| irq_oe | output | 1 | Interrupt drive enable (open-drain model) |
| ctl_a | output | DW | Control register A |
| ctl_b | output | DW | Control register B |
| tone | output | DW | Tone register |
| clko_sel | output | 1 | 1 selects the 16x baud clock, 0 the crystal clock |
| clko_baud | output | 1 | Divided baud clock stub |

## Verification
The bench runs a seeded random mix of latched reads and writes. These cover every address, with chip select both active and inactive, and with junk on `ad_in`/`cs_n` after the latch. This mix tells apart a design that uses the latched address and select from one that uses the live pins. Random event pulses placed between transfers check that flags stay set, and that only an active detect read clears them. Directed cases follow:
- an event in the very cycle a detect read starts, which separates a snapshot-and-clear from a clear that drops new events;
- every mode/request pairing for the clock select;
- toggle intervals in both DPSK modes;
- a reset taken in mid-run.

// File: rtl/mhr_pkg.sv
package mhr_pkg;

  localparam int AW = 3;

  localparam logic [AW-1:0] ADDR_CTL_A = 3'd0;
  localparam logic [AW-1:0] ADDR_CTL_B = 3'd1;
  localparam logic [AW-1:0] ADDR_DET   = 3'd2;
  localparam logic [AW-1:0] ADDR_TONE  = 3'd3;

  localparam int CLKREQ_BIT = 4;

  typedef enum logic [1:0] {
    MODE_FSK     = 2'b00,
    MODE_DPSK_LO = 2'b01,
    MODE_DPSK_HI = 2'b10,
    MODE_FSK_ALT = 2'b11
  } mode_e;

  typedef struct packed {
    logic ale_fall;
    logic wr_rise;
    logic rd_fall;
  } bus_evt_t;

  function automatic logic mode_is_dpsk(input logic [1:0] m);
    return (m == MODE_DPSK_LO) || (m == MODE_DPSK_HI);
  endfunction

  function automatic int unsigned half_period(input logic [1:0] m,
                                              input int unsigned div_lo,
                                              input int unsigned div_hi);
    return (m == MODE_DPSK_HI) ? (div_hi / 2) : (div_lo / 2);
  endfunction

  function automatic logic addr_is_rw(input logic [AW-1:0] a);
    return (a == ADDR_CTL_A) || (a == ADDR_CTL_B) || (a == ADDR_TONE);
  endfunction

endpackage

// File: rtl/mhr_bus_capture.sv
module mhr_bus_capture
  import mhr_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          ale,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] ad_addr,
  output logic [AW-1:0] addr_q,
  output logic          cs_held,
  output bus_evt_t      evt
);

  logic ale_q, rd_q, wr_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      ale_q <= 1'b0;
      rd_q  <= 1'b1;
      wr_q  <= 1'b1;
    end else begin
      ale_q <= ale;
      rd_q  <= rd_n;
      wr_q  <= wr_n;
    end
  end

  always_comb begin
    evt.ale_fall = ale_q & ~ale;
    evt.wr_rise  = ~wr_q & wr_n;
    evt.rd_fall  = rd_q & ~rd_n;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      addr_q  <= '0;
      cs_held <= 1'b0;
    end else if (evt.ale_fall) begin
      addr_q  <= ad_addr;
      cs_held <= ~cs_n;
    end
  end

  // R2: held select follows the pin only at the latch edge
  a_r2_cs_latched: assert property (@(posedge clk) disable iff (rst)
    !evt.ale_fall |=> $stable(cs_held));

endmodule

// File: rtl/mhr_regfile.sv
module mhr_regfile
  import mhr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_rise,
  input  logic          cs_held,
  input  logic [AW-1:0] addr_q,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctl_a,
  output logic [DW-1:0] ctl_b,
  output logic [DW-1:0] tone,
  output logic [DW-1:0] rdata
);

  logic wr_en;
  assign wr_en = wr_rise & cs_held;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      ctl_a <= '0;
      ctl_b <= '0;
      tone  <= '0;
    end else if (wr_en) begin
      case (addr_q)
        ADDR_CTL_A: ctl_a <= wdata;
        ADDR_CTL_B: ctl_b <= wdata;
        ADDR_TONE:  tone  <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_q)
      ADDR_CTL_A: rdata = ctl_a;
      ADDR_CTL_B: rdata = ctl_b;
      ADDR_TONE:  rdata = tone;
      default:    rdata = '0;
    endcase
  end

  // R4: a strobe without a held select leaves the registers alone
  a_r4_no_write_unselected: assert property (@(posedge clk) disable iff (rst)
    (wr_rise && !cs_held) |=> $stable({ctl_a, ctl_b, tone}));

  // R5: writes outside the read/write set change nothing
  a_r5_ro_unmapped_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_rise && !addr_is_rw(addr_q)) |=> $stable({ctl_a, ctl_b, tone}));

endmodule

// File: rtl/mhr_detect.sv
module mhr_detect #(
  parameter int DW   = 8,
  parameter int NDET = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NDET-1:0] det_evt,
  input  logic            rd_start,
  output logic [DW-1:0]   det_word,
  output logic            irq_n,
  output logic            irq_oe
);

  logic [NDET-1:0] flags, snap;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      flags <= '0;
      snap  <= '0;
    end else if (rd_start) begin
      snap  <= flags;
      flags <= det_evt;
    end else begin
      flags <= flags | det_evt;
    end
  end

  always_comb begin
    det_word = '0;
    det_word[NDET-1:0] = snap;
  end

  assign irq_oe = |flags;
  assign irq_n  = ~(|flags);

  // R6: interrupt holds until a detect read starts
  a_r6_irq_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq_oe && !rd_start) |=> irq_oe);

  // R8: events at read start survive into the flags
  a_r8_evt_kept: assert property (@(posedge clk) disable iff (rst)
    (rd_start && det_evt != '0) |=> ((flags & $past(det_evt)) == $past(det_evt)));

endmodule

// File: rtl/mhr_clkout.sv
module mhr_clkout
  import mhr_pkg::*;
#(
  parameter int DIV_LO = 16,
  parameter int DIV_HI = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       clk_req,
  output logic       clko_sel,
  output logic       clko_baud
);

  localparam int HMAX = ((DIV_LO > DIV_HI) ? DIV_LO : DIV_HI) / 2;
  localparam int CW   = $clog2(HMAX + 1) + 1;

  logic [CW-1:0] cnt, half;

  assign clko_sel = clk_req & mode_is_dpsk(mode);
  assign half     = CW'(half_period(mode, DIV_LO, DIV_HI));

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cnt       <= '0;
      clko_baud <= 1'b0;
    end else if (!clko_sel) begin
      cnt       <= '0;
      clko_baud <= 1'b0;
    end else if (cnt >= half - 1'b1) begin
      cnt       <= '0;
      clko_baud <= ~clko_baud;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R11: without the baud selection the stub output rests low
  a_r11_idle_low: assert property (@(posedge clk) disable iff (rst)
    !clko_sel |=> !clko_baud);

endmodule

// File: rtl/modem_host_regif.sv
module modem_host_regif
  import mhr_pkg::*;
#(
  parameter int DW     = 8,
  parameter int NDET   = 4,
  parameter int DIV_LO = 16,
  parameter int DIV_HI = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ale,
  input  logic            cs_n,
  input  logic            rd_n,
  input  logic            wr_n,
  input  logic [DW-1:0]   ad_in,
  output logic [DW-1:0]   ad_out,
  output logic            ad_oe,
  input  logic [NDET-1:0] det_evt,
  output logic            irq_n,
  output logic            irq_oe,
  output logic [DW-1:0]   ctl_a,
  output logic [DW-1:0]   ctl_b,
  output logic [DW-1:0]   tone,
  output logic            clko_sel,
  output logic            clko_baud
);

  logic [AW-1:0] addr_q;
  logic          cs_held;
  bus_evt_t      evt;
  logic [DW-1:0] reg_rdata, det_word;
  logic          det_rd_start;

  mhr_bus_capture u_cap (
    .clk(clk), .rst(rst), .ale(ale), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .ad_addr(ad_in[AW-1:0]), .addr_q(addr_q), .cs_held(cs_held), .evt(evt)
  );

  mhr_regfile #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_rise(evt.wr_rise), .cs_held(cs_held),
    .addr_q(addr_q), .wdata(ad_in), .ctl_a(ctl_a), .ctl_b(ctl_b),
    .tone(tone), .rdata(reg_rdata)
  );

  assign det_rd_start = evt.rd_fall & cs_held & (addr_q == ADDR_DET);

  mhr_detect #(.DW(DW), .NDET(NDET)) u_det (
    .clk(clk), .rst(rst), .det_evt(det_evt), .rd_start(det_rd_start),
    .det_word(det_word), .irq_n(irq_n), .irq_oe(irq_oe)
  );

  mhr_clkout #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_clk (
    .clk(clk), .rst(rst), .mode(ctl_a[1:0]), .clk_req(ctl_b[CLKREQ_BIT]),
    .clko_sel(clko_sel), .clko_baud(clko_baud)
  );

  assign ad_oe  = ~rd_n & cs_held;
  assign ad_out = !ad_oe ? '0 : ((addr_q == ADDR_DET) ? det_word : reg_rdata);

  // R3: nothing driven toward the bus outside an enabled read
  a_r3_quiet_bus: assert property (@(posedge clk) disable iff (rst)
    !ad_oe |-> (ad_out == '0));

endmodule

// File: tb/sim_modem_host_regif.sv
`timescale 1ns/1ps
module sim_modem_host_regif;

  localparam int DW = 8, NDET = 4, DIV_LO = 16, DIV_HI = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic ale = 1'b0, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [DW-1:0] ad_in = '0;
  logic [NDET-1:0] det_evt = '0;
  logic [DW-1:0] ad_out, ctl_a, ctl_b, tone;
  logic ad_oe, irq_n, irq_oe, clko_sel, clko_baud;

  int total = 0, bad = 0;
  bit done = 0;
  logic [DW-1:0] m_a, m_b, m_t;
  logic [NDET-1:0] m_flags;

  always #2.5 clk = ~clk;

  modem_host_regif #(.DW(DW), .NDET(NDET), .DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u0 (
    .clk(clk), .rst(rst), .ale(ale), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .det_evt(det_evt),
    .irq_n(irq_n), .irq_oe(irq_oe), .ctl_a(ctl_a), .ctl_b(ctl_b), .tone(tone),
    .clko_sel(clko_sel), .clko_baud(clko_baud)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_sel(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return b[4] && (a[1:0] == 2'd1 || a[1:0] == 2'd2);
  endfunction

  function automatic logic [DW-1:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return m_a;
      3'd1: return m_b;
      3'd2: return {{(DW-NDET){1'b0}}, m_flags};
      3'd3: return m_t;
      default: return '0;
    endcase
  endfunction

  task automatic latch(input logic [2:0] a, input bit cs);
    @(negedge clk); ale = 1'b1; ad_in = {$urandom} & 8'hF8 | {5'd0, a}; cs_n = ~cs;
    @(negedge clk); ale = 1'b0;
    @(negedge clk); ad_in = $urandom; cs_n = $urandom;   // R1 R2: junk after latch
  endtask

  task automatic bus_write(input logic [2:0] a, input bit cs, input logic [DW-1:0] d);
    latch(a, cs);
    @(negedge clk); ad_in = d; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); ad_in = $urandom;
    if (cs) begin
      if (a == 3'd0) m_a = d;
      if (a == 3'd1) m_b = d;
      if (a == 3'd3) m_t = d;
    end
  endtask

  task automatic bus_read(input logic [2:0] a, input bit cs, input logic [NDET-1:0] ev,
                          output logic [DW-1:0] d, output logic oe);
    latch(a, cs);
    @(negedge clk); rd_n = 1'b0; det_evt = ev;
    @(negedge clk); det_evt = '0; d = ad_out; oe = ad_oe; rd_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse(input logic [NDET-1:0] ev);
    @(negedge clk); det_evt = ev;
    @(negedge clk); det_evt = '0;
    m_flags |= ev;
  endtask

  task automatic read_check(input string req, input logic [2:0] a, input bit cs);
    logic [DW-1:0] d, e; logic oe;
    e = cs ? exp_read(a) : '0;
    bus_read(a, cs, '0, d, oe);
    check({req, " oe"}, {31'd0, oe}, {31'd0, cs});
    check({req, " data"}, {24'd0, d}, {24'd0, e});
    if (cs && a == 3'd2) m_flags = '0;
  endtask

  task automatic measure(input string req, input int exp_half);
    logic prev; int n;
    n = 0;
    @(negedge clk); prev = clko_baud;
    while (clko_baud == prev && n < 100) begin @(negedge clk); n++; end
    prev = clko_baud; n = 0;
    while (clko_baud == prev && n < 100) begin @(negedge clk); n++; end
    check(req, n, exp_half);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d; logic oe;
    void'($urandom(32'd4242));
    m_a = '0; m_b = '0; m_t = '0; m_flags = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check("R9 clko_sel", {31'd0, clko_sel}, 0);
    check("R9 irq_oe", {31'd0, irq_oe}, 0);
    check("R3 oe idle", {31'd0, ad_oe}, 0);
    check("R11 baud idle", {31'd0, clko_baud}, 0);

    // R1 R2 R4 R5 R6 R7: random mix
    for (int i = 0; i < 120; i++) begin
      logic [2:0] a; bit cs; int op;
      a = $urandom % 8; cs = ($urandom % 4) != 0; op = $urandom % 3;
      if (($urandom % 4) == 0) pulse($urandom % 16);
      if (m_flags != '0) begin
        check("R6 irq_oe", {31'd0, irq_oe}, 1);
        check("R6 irq_n", {31'd0, irq_n}, 0);
      end
      if (op == 0) bus_write(a, cs, $urandom);
      else read_check("R1 R2 R4 R5 R7 random", a, cs);
    end

    // R5: detect register ignores writes
    read_check("R7 drain", 3'd2, 1);
    pulse(4'b0101);
    bus_write(3'd2, 1, 8'hFF);
    read_check("R5 det ro", 3'd2, 1);
    check("R7 irq released", {31'd0, irq_oe}, 0);
    bus_write(3'd6, 1, 8'hA5);
    read_check("R5 unmapped", 3'd6, 1);

    // R8: event at read start kept for next read
    pulse(4'b0010);
    bus_read(3'd2, 1, 4'b1000, d, oe);
    check("R8 first read", {24'd0, d}, 32'h02);
    check("R8 irq kept", {31'd0, irq_oe}, 1);
    m_flags = 4'b1000;
    read_check("R8 second read", 3'd2, 1);

    // R3: unselected read drives nothing
    bus_read(3'd0, 0, '0, d, oe);
    check("R3 unselected oe", {31'd0, oe}, 0);
    check("R3 unselected data", {24'd0, d}, 0);

    // R10: every mode and request pairing
    for (int m = 0; m < 4; m++) begin
      for (int r = 0; r < 2; r++) begin
        bus_write(3'd0, 1, 8'(m));
        bus_write(3'd1, 1, 8'(r << 4));
        check("R10 select", {31'd0, clko_sel}, {31'd0, exp_sel(m_a, m_b)});
      end
    end

    // R11: toggle intervals
    bus_write(3'd0, 1, 8'h01);
    bus_write(3'd1, 1, 8'h10);
    measure("R11 low rate half", DIV_LO / 2);
    bus_write(3'd0, 1, 8'h02);
    measure("R11 high rate half", DIV_HI / 2);
    bus_write(3'd0, 1, 8'h00);
    repeat (3) @(negedge clk);
    check("R11 off low", {31'd0, clko_baud}, 0);

    // R9: reset mid-run
    bus_write(3'd0, 1, 8'h02);
    bus_write(3'd3, 1, 8'h5C);
    pulse(4'b0001);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    m_a = '0; m_b = '0; m_t = '0; m_flags = '0;
    check("R9 sel after reset", {31'd0, clko_sel}, 0);
    check("R9 irq after reset", {31'd0, irq_oe}, 0);
    read_check("R9 ctl_a", 3'd0, 1);
    read_check("R9 ctl_b", 3'd1, 1);
    read_check("R9 tone", 3'd3, 1);
    read_check("R9 detect", 3'd2, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule